// File: doc/BRIEF.md
# GPIO Pad Controller with Banked Interrupts

This block controls a parameterised set of general-purpose pads (up to 78 by default) through a flat 32-bit register bus. Every pad owns one configuration word. That word sets the pad's output drive level and shows the pad's synchronised input level. It also holds an input-inversion control and a two-bit detection mode. Software writes the drive bit to steer `pad_out`, and reads the input bit to sample `pad_in` after a two-flop synchroniser.

Each pad feeds an event detector. The detector looks at the synchronised input after the optional inversion and fires on a level, on a rising edge, or on either edge. Detected events collect in status words of 32 pads each, and software clears them by writing ones. Separate enable words of the same banking gate the status bits. One registered interrupt line signals when any enabled status bit is set. Bus reads are combinational from the address. A write takes effect at the rising clock edge on which `bus_we` is high.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every status word, every enable word, every pad configuration word, every bit of `pad_out` and `irq` is zero.
- R2: The configuration word of pad n lives at byte address 0x500 + 8·n. Bit 0 is the drive value: it reads back as written and appears on `pad_out[n]` one clock after the write.
- R3: Configuration bit 1 reads the synchronised level of `pad_in[n]`, two clocks after the input changes. Writes to bit 1 are ignored. Every bit other than 0, 1, 23, 25 and 26 reads as zero.
- R4: Configuration bit 23, when set, inverts the synchronised input before event detection.
- R5: Mode bits 26:25 = 00 select level detection. The status bit is set on every clock in which the (possibly inverted) input is high, so a clear does not stick while that level lasts.
- R6: Mode 01 sets the status bit once on each low-to-high transition of the (possibly inverted) input. A clear then sticks while the input stays high, and a falling transition sets nothing.
- R7: Mode 11 sets the status bit on both rising and falling transitions of the (possibly inverted) input.
- R8: Mode 10 disables detection: input transitions never set the status bit.
- R9: The status word of bank b is at 0x100 + 4·b, and pad n is bit n%32 of bank n/32. A status bit, once set, stays set until it is cleared. Writing a one clears that bit and writing a zero leaves it unchanged. An event in the same clock as a clearing write wins, and the bit stays set.
- R10: The enable word of bank b is at 0x110 + 4·b and reads back as written. `irq` is high one clock after any status bit and its enable bit are both set, and it is low one clock after no such pair remains.
- R11: Status and enable bits of pads at or above NUM_PADS read as zero and ignore writes. Bank words above the last bank, and configuration addresses of pads that do not exist, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Pad drive levels from configuration bit 0 |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The status bits and the previous-level registers in the detectors are the state that matters most. A wrong previous level shows up as a missing or extra status bit, which can be read three clocks after the input moves. A stuck or wrongly masked enable bit shows on `irq` one clock after the status or enable write. A corrupt configuration field reads back wrongly at once. It also changes the detection behaviour of its pad on the next input transition, and that difference is visible through the status word of the pad's bank.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int WORD_W      = 32;
  localparam int MAX_BANKS   = 4;
  localparam int STS_BASE    = 'h100;
  localparam int EN_BASE     = 'h110;
  localparam int CFG_BASE    = 'h500;
  localparam int CFG_STEP_LG = 3;

  localparam int BIT_DRIVE   = 0;
  localparam int BIT_LEVEL   = 1;
  localparam int BIT_INVERT  = 23;
  localparam int BIT_MODE_LO = 25;
  localparam int BIT_MODE_HI = 26;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'b00,
    DET_RISE  = 2'b01,
    DET_OFF   = 2'b10,
    DET_BOTH  = 2'b11
  } det_mode_e;

  typedef struct packed {
    logic      drive;
    logic      invert;
    det_mode_e mode;
  } pad_cfg_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              in_sync,
  output logic              drive,
  output logic              evt,
  output logic [WORD_W-1:0] rd_word
);

  pad_cfg_t cfg_q, cfg_d;
  logic     prev_q, prev_d;
  logic     lvl;

  always_comb begin
    cfg_d        = cfg_q;
    cfg_d.drive  = wdata[BIT_DRIVE];
    cfg_d.invert = wdata[BIT_INVERT];
    cfg_d.mode   = det_mode_e'(wdata[BIT_MODE_HI:BIT_MODE_LO]);
  end

  assign lvl    = in_sync ^ cfg_q.invert;
  assign prev_d = lvl;

  always_comb begin
    case (cfg_q.mode)
      DET_LEVEL: evt = lvl;
      DET_RISE:  evt = lvl & ~prev_q;
      DET_BOTH:  evt = lvl ^ prev_q;
      default:   evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rd_word                          = '0;
    rd_word[BIT_DRIVE]               = cfg_q.drive;
    rd_word[BIT_LEVEL]               = in_sync;
    rd_word[BIT_INVERT]              = cfg_q.invert;
    rd_word[BIT_MODE_HI:BIT_MODE_LO] = cfg_q.mode;
  end

  assign drive = cfg_q.drive;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int NUM_PADS = 78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt,
  input  logic              sts_we,
  input  logic              en_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] sts_q,
  output logic [WORD_W-1:0] en_q
);

  function automatic logic [WORD_W-1:0] live_mask(int bank, int npads);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = ((bank * WORD_W + i) < npads);
    end
    return m;
  endfunction

  localparam logic [WORD_W-1:0] LIVE = live_mask(BANK_IDX, NUM_PADS);

  logic [WORD_W-1:0] sts_d, en_d, clr;

  always_comb begin
    clr   = sts_we ? wdata : '0;
    sts_d = ((sts_q & ~clr) | evt) & LIVE;
    en_d  = wdata & LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PADS = 78,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic                irq
);

  localparam int NBANKS = (NUM_PADS + WORD_W - 1) / WORD_W;
  localparam int FLAT_W = MAX_BANKS * WORD_W;
  localparam int IDX_W  = ADDR_W - CFG_STEP_LG;
  localparam int PAGE_W = ADDR_W - 4;

  localparam logic [ADDR_W-1:0] CFG_BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [PAGE_W-1:0] STS_PAGE   = PAGE_W'(STS_BASE >> 4);
  localparam logic [PAGE_W-1:0] EN_PAGE    = PAGE_W'(EN_BASE >> 4);
  localparam logic [IDX_W-1:0]  NPADS_IDX  = IDX_W'(NUM_PADS);

  logic                rst_sync_n;
  logic [NUM_PADS-1:0] in_sync;
  logic [NUM_PADS-1:0] pad_evt;
  logic [WORD_W-1:0]   pad_rd [NUM_PADS];
  logic [FLAT_W-1:0]   evt_flat;
  logic [FLAT_W-1:0]   sts_flat;
  logic [FLAT_W-1:0]   en_flat;

  logic [ADDR_W-1:0]   cfg_off;
  logic [IDX_W-1:0]    cfg_idx;
  logic                cfg_hit;
  logic                sts_hit;
  logic                en_hit;
  logic [1:0]          word_sel;
  logic                irq_d, irq_q;

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(NUM_PADS)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  // Address decode
  always_comb begin
    cfg_off  = bus_addr - CFG_BASE_A;
    cfg_idx  = cfg_off[ADDR_W-1:CFG_STEP_LG];
    cfg_hit  = (bus_addr >= CFG_BASE_A) && (bus_addr[CFG_STEP_LG-1:0] == '0) &&
               (cfg_idx < NPADS_IDX);
    sts_hit  = (bus_addr[ADDR_W-1:4] == STS_PAGE) && (bus_addr[1:0] == 2'b00);
    en_hit   = (bus_addr[ADDR_W-1:4] == EN_PAGE) && (bus_addr[1:0] == 2'b00);
    word_sel = bus_addr[3:2];
  end

  // Pad cells
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic cell_we;
    assign cell_we = bus_we && cfg_hit && (cfg_idx == IDX_W'(p));

    gpio_pad_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .cfg_we  (cell_we),
      .wdata   (bus_wdata),
      .in_sync (in_sync[p]),
      .drive   (pad_out[p]),
      .evt     (pad_evt[p]),
      .rd_word (pad_rd[p])
    );
  end

  assign evt_flat = FLAT_W'(pad_evt);

  // Interrupt banks; word slots above the pad count stay empty
  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NBANKS) begin : g_live
      logic bank_sts_we, bank_en_we;
      assign bank_sts_we = bus_we && sts_hit && (word_sel == 2'(b));
      assign bank_en_we  = bus_we && en_hit  && (word_sel == 2'(b));

      gpio_irq_bank #(.BANK_IDX(b), .NUM_PADS(NUM_PADS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .evt    (evt_flat[b*WORD_W +: WORD_W]),
        .sts_we (bank_sts_we),
        .en_we  (bank_en_we),
        .wdata  (bus_wdata),
        .sts_q  (sts_flat[b*WORD_W +: WORD_W]),
        .en_q   (en_flat[b*WORD_W +: WORD_W])
      );
    end else begin : g_empty
      assign sts_flat[b*WORD_W +: WORD_W] = '0;
      assign en_flat[b*WORD_W +: WORD_W]  = '0;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (cfg_idx == IDX_W'(p)) begin
          bus_rdata = pad_rd[p];
        end
      end
    end else if (sts_hit || en_hit) begin
      for (int b = 0; b < MAX_BANKS; b++) begin
        if (word_sel == 2'(b)) begin
          bus_rdata = sts_hit ? sts_flat[b*WORD_W +: WORD_W]
                              : en_flat[b*WORD_W +: WORD_W];
        end
      end
    end
  end

  // Combined interrupt
  assign irq_d = |(sts_flat & en_flat);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PADS = 78,
  parameter int ADDR_W   = 12,
  parameter int FLAT_W   = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] evt,
  input logic [FLAT_W-1:0]   sts_flat,
  input logic [FLAT_W-1:0]   en_flat,
  input logic                irq
);

  logic cfg0_wr, sts0_clr;
  assign cfg0_wr  = bus_we && (bus_addr == ADDR_W'(CFG_BASE));
  assign sts0_clr = bus_we && (bus_addr == ADDR_W'(STS_BASE)) && bus_wdata[0];

  assert_cfg_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg0_wr |=> (pad_out[0] == $past(bus_wdata[0])));

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> sts_flat[0]);

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts0_clr && !evt[0]) |=> !sts_flat[0]);

  assert_status_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flat[0] && !sts0_clr) |=> sts_flat[0]);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_flat == '0) |=> !irq);

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
  .NUM_PADS (NUM_PADS),
  .ADDR_W   (ADDR_W),
  .FLAT_W   (FLAT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_out   (pad_out),
  .evt       (pad_evt),
  .sts_flat  (sts_flat),
  .en_flat   (en_flat),
  .irq       (irq)
);

// File: tb/tb_gpio_pad_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_pad_ctrl;

  localparam int NP = 78;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_pad_ctrl #(.NUM_PADS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .irq(irq)
  );

  function automatic logic [AW-1:0] cfg_addr(int n);
    return AW'('h500 + 8 * n);
  endfunction

  function automatic logic [AW-1:0] sts_addr(int b);
    return AW'('h100 + 4 * b);
  endfunction

  function automatic logic [AW-1:0] en_addr(int b);
    return AW'('h110 + 4 * b);
  endfunction

  function automatic logic [31:0] cfg_expect(logic [31:0] w, logic lvl);
    return (w & 32'h0680_0001) | {30'd0, lvl, 1'b0};
  endfunction

  function automatic logic [31:0] en_mask(int b);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = ((b * 32 + i) < NP);
    return m;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pad(int n, logic v);
    @(negedge clk);
    pad_in[n] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic sts_bit(int n, output logic [31:0] bitv);
    logic [31:0] w;
    bus_read(sts_addr(n / 32), w);
    bitv = {31'd0, w[n % 32]};
  endtask

  task automatic clear_all();
    for (int b = 0; b < 3; b++) bus_write(sts_addr(b), 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] rd, w, seedv;
    int n, b;
    seedv     = $urandom(32'h5EED_0042);
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    pad_in    = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      bus_read(sts_addr(i), rd); check("R1 status", rd, 0);
      bus_read(en_addr(i), rd);  check("R1 enable", rd, 0);
    end
    bus_read(cfg_addr(0), rd);  check("R1 cfg pad0", rd, 0);
    bus_read(cfg_addr(77), rd); check("R1 cfg pad77", rd, 0);
    check("R1 pad_out", {31'd0, |pad_out}, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R2/R3 highest pad, all bits written
    bus_write(cfg_addr(77), 32'hFFFF_FFFF);
    bus_read(cfg_addr(77), rd); check("R3 cfg readback masks", rd, 32'h0680_0001);
    check("R2 pad_out77", {31'd0, pad_out[77]}, 1);
    set_pad(77, 1'b1);
    bus_read(cfg_addr(77), rd); check("R3 input level", rd, 32'h0680_0003);
    bus_write(cfg_addr(77), 32'h0000_0000);
    bus_read(cfg_addr(77), rd); check("R2 drive cleared", rd, 32'h0000_0002);
    set_pad(77, 1'b0);

    // R11 boundaries
    bus_read(cfg_addr(78), rd); check("R11 absent pad", rd, 0);
    bus_write(en_addr(2), 32'hFFFF_FFFF);
    bus_read(en_addr(2), rd); check("R11 enable top bank mask", rd, en_mask(2));
    bus_write(en_addr(2), 32'h0);
    bus_write(sts_addr(3), 32'hFFFF_FFFF);
    bus_read(sts_addr(3), rd); check("R11 status word above banks", rd, 0);
    bus_write(en_addr(3), 32'hFFFF_FFFF);
    bus_read(en_addr(3), rd); check("R11 enable word above banks", rd, 0);

    // Random config writes on a random steady input pattern
    @(negedge clk);
    pad_in = NP'({$urandom, $urandom, $urandom});
    repeat (3) @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      n = $urandom_range(0, NP - 1);
      w = $urandom;
      bus_write(cfg_addr(n), w);
      bus_read(cfg_addr(n), rd); check("R3 random cfg readback", rd, cfg_expect(w, pad_in[n]));
      check("R2 random drive", {31'd0, pad_out[n]}, {31'd0, w[0]});
    end
    for (int k = 0; k < 6; k++) begin
      b = $urandom_range(0, 2);
      w = $urandom;
      bus_write(en_addr(b), w);
      bus_read(en_addr(b), rd); check("R10 random enable readback", rd, w & en_mask(b));
    end
    for (int i = 0; i < 3; i++) bus_write(en_addr(i), 32'h0);
    @(negedge clk);
    pad_in = '0;
    for (int i = 0; i < NP; i++) bus_write(cfg_addr(i), 32'h0);
    repeat (3) @(negedge clk);
    clear_all();

    // R5 level mode, pad 5
    sts_bit(5, rd); check("R5 idle low", rd, 0);
    set_pad(5, 1'b1);
    sts_bit(5, rd); check("R5 level sets", rd, 1);
    bus_write(sts_addr(0), 32'h0000_0020);
    sts_bit(5, rd); check("R9 event beats clear", rd, 1);
    set_pad(5, 1'b0);
    bus_write(sts_addr(0), 32'h0000_0020);
    sts_bit(5, rd); check("R5 clear after level drops", rd, 0);

    // R4 inversion
    bus_write(cfg_addr(5), 32'h0080_0000);
    @(negedge clk);
    sts_bit(5, rd); check("R4 inverted low input sets", rd, 1);
    set_pad(5, 1'b1);
    bus_write(sts_addr(0), 32'h0000_0020);
    sts_bit(5, rd); check("R4 inverted high input quiet", rd, 0);
    bus_write(cfg_addr(5), 32'h0);
    set_pad(5, 1'b0);
    clear_all();

    // R6 rising edge, pad 40
    bus_write(cfg_addr(40), 32'h0200_0000);
    clear_all();
    sts_bit(40, rd); check("R6 idle", rd, 0);
    set_pad(40, 1'b1);
    sts_bit(40, rd); check("R6 rise sets", rd, 1);
    bus_write(sts_addr(1), 32'h0000_0100);
    @(negedge clk);
    sts_bit(40, rd); check("R6 clear sticks while high", rd, 0);
    set_pad(40, 1'b0);
    sts_bit(40, rd); check("R6 fall ignored", rd, 0);

    // R7 both edges
    bus_write(cfg_addr(40), 32'h0600_0000);
    clear_all();
    sts_bit(40, rd); check("R7 idle", rd, 0);
    set_pad(40, 1'b1);
    sts_bit(40, rd); check("R7 rise sets", rd, 1);
    bus_write(sts_addr(1), 32'h0000_0100);
    sts_bit(40, rd); check("R7 cleared", rd, 0);
    set_pad(40, 1'b0);
    sts_bit(40, rd); check("R7 fall sets", rd, 1);

    // R8 detection off, pad 77
    bus_write(cfg_addr(77), 32'h0400_0000);
    clear_all();
    set_pad(77, 1'b1);
    sts_bit(77, rd); check("R8 rise ignored", rd, 0);
    set_pad(77, 1'b0);
    sts_bit(77, rd); check("R8 fall ignored", rd, 0);

    // R10 interrupt gating, pad 40 in rising mode
    bus_write(cfg_addr(40), 32'h0200_0000);
    clear_all();
    set_pad(40, 1'b1);
    @(negedge clk);
    check("R10 irq masked", {31'd0, irq}, 0);
    bus_write(en_addr(1), 32'h0000_0100);
    @(negedge clk);
    check("R10 irq rises", {31'd0, irq}, 1);
    bus_write(sts_addr(1), 32'h0000_0000);
    sts_bit(40, rd); check("R9 zero write keeps bit", rd, 1);
    check("R10 irq stays", {31'd0, irq}, 1);
    bus_write(sts_addr(1), 32'h0000_0100);
    @(negedge clk);
    check("R10 irq falls", {31'd0, irq}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule